// File: doc/BRIEF.md
# Adapter Host Register Window

This block is the host-facing glue of a network adapter. A small host I/O window is shared between two targets: the system interface registers of a network controller, and an identity ROM that holds the card's manufacturer byte, card type, revision, a mirror of its configuration bytes and its six-byte station address. Control register 0 chooses which target is visible and which ROM page is shown. The window has fewer address lines than the controller has register offsets. The missing top register-select bit therefore comes from a page bit in control register 1.

Control register 1 also drives the controller's active-low reset, the line-speed select and the interrupt enable. A request from the controller sets an interrupt latch. The latch drives a level-sensitive host line, which several adapters can share, only while the enable bit is set. To clear the latch, the host turns the enable bit off and then on again. A third register selects the cable type.

Host address bit `WIN_AW` picks the region. When it is 0, offsets 0 to 7 address the shared window. When it is 1, the low bits index the control registers: 0, 1 and 7 are implemented. Reads are combinational in the cycle `h_rd` is high. Writes take effect at the rising clock edge of the cycle `h_wr` is high.

Top module: `nic_glue_window`

## Requirements
- R1: After reset, control registers 0, 1 and 7 read 0x00, `c_rst_n`, `h_irq`, `speed_hi` and `cable_utp` are 0, and the window shows the ROM.
- R2: Control registers 0 (index 0), 1 (index 1) and 7 (index 7) read back the low byte last written. The exception is control register 0 bit 7, which is the read-only interrupt status. Indices 2 to 6 read 0 and ignore writes.
- R3: With control register 0 bit 2 = 0 and bit 3 = 0, window offsets read as follows: offset 0 gives the manufacturer byte, 1 the card type, 2 the revision, 3 to 5 configuration bytes 0 to 2, and 6 and 7 give 0. The byte appears in `h_rdata[7:0]` with the upper byte 0.
- R4: With bit 2 = 0 and bit 3 = 1, offsets 1 to 6 return the station address, most significant byte at offset 1. Offsets 0 and 7 read 0.
- R5: While bit 2 of control register 0 is 0, window accesses never assert `c_rd` or `c_wr`, and window writes change nothing.
- R6: While bit 2 is 1, a window access reaches the controller at `c_addr = {ctrl1 bit 2, offset}`. Host offset o with the page bit set therefore reaches controller offset o + 8.
- R7: Control register 1 bit 0 drives `c_rst_n`: 0 holds the controller in reset and 1 releases it.
- R8: A high `c_irq` sets the interrupt latch at the next clock edge. The latch reads as control register 0 bit 7, and `h_irq` is high only while the latch and control register 1 bit 1 are both 1.
- R9: A write to control register 1 that takes bit 1 from 1 to 0 clears the latch. If `c_irq` is high in that same cycle, the latch stays set. A write that leaves bit 1 at 0 does not clear the latch.
- R10: Control register 1 bit 3 drives `speed_hi` (1 for the higher speed). Control register 7 bit 0 drives `cable_utp` (1 for unshielded, 0 for shielded).
- R11: Word accesses to the controller pass all 16 bits with `c_be = 2'b11`. Byte accesses carry data on the host low byte. Even offsets use the controller low lane (`c_be = 2'b01`) and odd offsets the high lane (`c_be = 2'b10`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | WIN_AW+1 | Host offset; top bit selects the control region |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| h_wdata | input | 16 | Host write data; bytes on the low lane |
| h_rdata | output | 16 | Host read data |
| h_irq | output | 1 | Level-sensitive shared host interrupt |
| c_addr | output | WIN_AW+1 | Controller register select, top bit from the page bit |
| c_rd | output | 1 | Controller read strobe |
| c_wr | output | 1 | Controller write strobe |
| c_be | output | 2 | Controller byte-lane enables |
| c_wdata | output | 16 | Controller write data |
| c_rdata | input | 16 | Controller read data |
| c_irq | input | 1 | Controller interrupt request |
| c_rst_n | output | 1 | Active-low controller reset |
| speed_hi | output | 1 | Line-speed select to the line interface |
| cable_utp | output | 1 | Cable-type select |
| cfg_bytes | input | 8*CFG_BYTES | Configuration bytes mirrored into ROM page zero |

## Verification
A controller request and a clearing write can land in the same cycle. That happens when the host's disable write to control register 1 coincides with a high `c_irq`. The bench provokes it by holding the request high across the off-then-on toggle of the enable bit. It then judges the result through the status bit and `h_irq`, expecting the latch to survive. The opposite case is also run: a request is dropped before the toggle and the latch must clear. A write that leaves the enable already low must not clear the latch.

// File: rtl/glue_pkg.sv
package glue_pkg;
   // control register 0 fields
   localparam int C0_PAGE    = 3;
   localparam int C0_MAP     = 2;
   localparam int C0_IRQ_STS = 7;
   // control register 1 fields
   localparam int C1_NRST    = 0;
   localparam int C1_IEN     = 1;
   localparam int C1_RPAGE   = 2;
   localparam int C1_SPEED   = 3;
   // control register 7 fields
   localparam int C7_CABLE   = 0;
   // control register indices
   localparam int IDX_C0     = 0;
   localparam int IDX_C1     = 1;
   localparam int IDX_C7     = 7;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_CTRL = 2'd1,
      ACC_CTLR = 2'd2,
      ACC_ROM  = 2'd3
   } acc_e;
endpackage

// File: rtl/glue_decode.sv
module glue_decode
   import glue_pkg::*;
#(
   parameter int WIN_AW = 3
)(
   input  logic [WIN_AW:0] addr,
   input  logic            rd,
   input  logic            wr,
   input  logic            map_en,
   output acc_e            kind
);
   always_comb begin
      if (!(rd || wr))       kind = ACC_NONE;
      else if (addr[WIN_AW]) kind = ACC_CTRL;
      else if (map_en)       kind = ACC_CTLR;
      else                   kind = ACC_ROM;
   end
endmodule

// File: rtl/glue_ctrl_regs.sv
module glue_ctrl_regs
   import glue_pkg::*;
#(
   parameter int WIN_AW          = 3,
   parameter int CTRL_W          = 8,
   parameter int IRQ_SYNC_STAGES = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIN_AW-1:0] idx,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              irq_req,
   output logic [CTRL_W-1:0] ctrl0_rd,
   output logic [CTRL_W-1:0] ctrl1_q,
   output logic [CTRL_W-1:0] ctrl7_q,
   output logic              irq_latch_q
);
   logic [CTRL_W-1:0] ctrl0_st;
   logic              irq_s;
   logic              wr_c0, wr_c1, wr_c7, clr_latch;

   // optional request synchroniser
   generate
      if (IRQ_SYNC_STAGES == 0) begin : g_irq_direct
         assign irq_s = irq_req;
      end else begin : g_irq_sync
         logic [IRQ_SYNC_STAGES-1:0] shr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shr <= '0;
            end else begin
               shr[0] <= irq_req;
               for (int i = 1; i < IRQ_SYNC_STAGES; i++) shr[i] <= shr[i-1];
            end
         end
         assign irq_s = shr[IRQ_SYNC_STAGES-1];
      end
   endgenerate

   assign wr_c0 = wr_en && (idx == WIN_AW'(IDX_C0));
   assign wr_c1 = wr_en && (idx == WIN_AW'(IDX_C1));
   assign wr_c7 = wr_en && (idx == WIN_AW'(IDX_C7));

   // enable going 1 -> 0 clears the latch
   assign clr_latch = wr_c1 && ctrl1_q[C1_IEN] && !wdata[C1_IEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl0_st    <= '0;
         ctrl1_q     <= '0;
         ctrl7_q     <= '0;
         irq_latch_q <= 1'b0;
      end else begin
         if (wr_c0) begin
            ctrl0_st             <= wdata;
            ctrl0_st[C0_IRQ_STS] <= 1'b0;
         end
         if (wr_c1) ctrl1_q <= wdata;
         if (wr_c7) ctrl7_q <= wdata;
         // a pending request wins over a clear in the same cycle
         if (irq_s)          irq_latch_q <= 1'b1;
         else if (clr_latch) irq_latch_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl0_rd             = ctrl0_st;
      ctrl0_rd[C0_IRQ_STS] = irq_latch_q;
   end
endmodule

// File: rtl/glue_id_rom.sv
module glue_id_rom #(
   parameter int                     WIN_AW       = 3,
   parameter int                     CFG_BYTES    = 3,
   parameter int                     SA_BYTES     = 6,
   parameter logic [7:0]             MANUF_ID     = 8'h4D,
   parameter logic [7:0]             CARD_ID      = 8'h08,
   parameter logic [7:0]             CARD_REV     = 8'h00,
   parameter logic [SA_BYTES*8-1:0]  STATION_ADDR = '0
)(
   input  logic                   page,
   input  logic [WIN_AW-1:0]      off,
   input  logic [CFG_BYTES*8-1:0] cfg,
   output logic [7:0]             rom_byte
);
   localparam int SLOTS    = 1 << WIN_AW;
   localparam int CFG_BASE = 3;

   logic [7:0] pg0 [SLOTS];
   logic [7:0] pg1 [SLOTS];

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         if (s == 0) begin : g_p0_man
            assign pg0[s] = MANUF_ID;
         end else if (s == 1) begin : g_p0_card
            assign pg0[s] = CARD_ID;
         end else if (s == 2) begin : g_p0_rev
            assign pg0[s] = CARD_REV;
         end else if (s < CFG_BASE + CFG_BYTES) begin : g_p0_cfg
            assign pg0[s] = cfg[(s-CFG_BASE)*8 +: 8];
         end else begin : g_p0_zero
            assign pg0[s] = 8'h00;
         end

         if (s >= 1 && s <= SA_BYTES) begin : g_p1_sa
            assign pg1[s] = STATION_ADDR[(SA_BYTES-s)*8 +: 8];
         end else begin : g_p1_zero
            assign pg1[s] = 8'h00;
         end
      end
   endgenerate

   assign rom_byte = page ? pg1[off] : pg0[off];
endmodule

// File: rtl/glue_lane.sv
module glue_lane #(
   parameter int DATA_W = 16
)(
   input  logic              word,
   input  logic              odd,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic [DATA_W-1:0] c_rdata,
   output logic [DATA_W-1:0] c_wdata,
   output logic [1:0]        be,
   output logic [DATA_W-1:0] rd_data
);
   localparam int LANE_W = DATA_W / 2;

   always_comb begin
      if (word) begin
         c_wdata = h_wdata;
         be      = 2'b11;
         rd_data = c_rdata;
      end else if (odd) begin
         c_wdata = {h_wdata[LANE_W-1:0], {LANE_W{1'b0}}};
         be      = 2'b10;
         rd_data = {{LANE_W{1'b0}}, c_rdata[DATA_W-1:LANE_W]};
      end else begin
         c_wdata = {{LANE_W{1'b0}}, h_wdata[LANE_W-1:0]};
         be      = 2'b01;
         rd_data = {{LANE_W{1'b0}}, c_rdata[LANE_W-1:0]};
      end
   end
endmodule

// File: rtl/nic_glue_window.sv
module nic_glue_window
   import glue_pkg::*;
#(
   parameter int                    WIN_AW          = 3,
   parameter int                    DATA_W          = 16,
   parameter int                    CTRL_W          = 8,
   parameter int                    CFG_BYTES       = 3,
   parameter int                    SA_BYTES        = 6,
   parameter logic [7:0]            MANUF_ID        = 8'h4D,
   parameter logic [7:0]            CARD_ID         = 8'h08,
   parameter logic [7:0]            CARD_REV        = 8'h00,
   parameter logic [SA_BYTES*8-1:0] STATION_ADDR    = '0,
   parameter int                    IRQ_SYNC_STAGES = 0,
   localparam int                   ADDR_W          = WIN_AW + 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      h_addr,
   input  logic                   h_rd,
   input  logic                   h_wr,
   input  logic                   h_word,
   input  logic [DATA_W-1:0]      h_wdata,
   output logic [DATA_W-1:0]      h_rdata,
   output logic                   h_irq,
   output logic [ADDR_W-1:0]      c_addr,
   output logic                   c_rd,
   output logic                   c_wr,
   output logic [1:0]             c_be,
   output logic [DATA_W-1:0]      c_wdata,
   input  logic [DATA_W-1:0]      c_rdata,
   input  logic                   c_irq,
   output logic                   c_rst_n,
   output logic                   speed_hi,
   output logic                   cable_utp,
   input  logic [CFG_BYTES*8-1:0] cfg_bytes
);
   // elaboration checks
   if (WIN_AW < 3) begin : g_bad_aw
      $error("WIN_AW must be at least 3");
   end
   if (DATA_W != 16) begin : g_bad_dw
      $error("DATA_W must be 16");
   end
   if (CTRL_W < 8 || CTRL_W > DATA_W) begin : g_bad_cw
      $error("CTRL_W must lie in 8..DATA_W");
   end
   if (SA_BYTES + 1 > (1 << WIN_AW) || 3 + CFG_BYTES > (1 << WIN_AW)) begin : g_bad_rom
      $error("ROM contents do not fit the window");
   end

   acc_e              kind;
   logic [CTRL_W-1:0] ctrl0_q, ctrl1_q, ctrl7_q;
   logic              irq_latch_q;
   logic [7:0]        rom_byte;
   logic [DATA_W-1:0] ctlr_rd;
   logic [CTRL_W-1:0] ctrl_rd;
   logic [WIN_AW-1:0] off;

   assign off = h_addr[WIN_AW-1:0];

   glue_decode #(.WIN_AW(WIN_AW)) u_dec (
      .addr   (h_addr),
      .rd     (h_rd),
      .wr     (h_wr),
      .map_en (ctrl0_q[C0_MAP]),
      .kind   (kind)
   );

   glue_ctrl_regs #(
      .WIN_AW          (WIN_AW),
      .CTRL_W          (CTRL_W),
      .IRQ_SYNC_STAGES (IRQ_SYNC_STAGES)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (h_wr && kind == ACC_CTRL),
      .idx         (off),
      .wdata       (h_wdata[CTRL_W-1:0]),
      .irq_req     (c_irq),
      .ctrl0_rd    (ctrl0_q),
      .ctrl1_q     (ctrl1_q),
      .ctrl7_q     (ctrl7_q),
      .irq_latch_q (irq_latch_q)
   );

   glue_id_rom #(
      .WIN_AW       (WIN_AW),
      .CFG_BYTES    (CFG_BYTES),
      .SA_BYTES     (SA_BYTES),
      .MANUF_ID     (MANUF_ID),
      .CARD_ID      (CARD_ID),
      .CARD_REV     (CARD_REV),
      .STATION_ADDR (STATION_ADDR)
   ) u_rom (
      .page     (ctrl0_q[C0_PAGE]),
      .off      (off),
      .cfg      (cfg_bytes),
      .rom_byte (rom_byte)
   );

   glue_lane #(.DATA_W(DATA_W)) u_lane (
      .word    (h_word),
      .odd     (off[0]),
      .h_wdata (h_wdata),
      .c_rdata (c_rdata),
      .c_wdata (c_wdata),
      .be      (c_be),
      .rd_data (ctlr_rd)
   );

   // controller side
   assign c_addr  = {ctrl1_q[C1_RPAGE], off};
   assign c_rd    = h_rd && kind == ACC_CTLR;
   assign c_wr    = h_wr && kind == ACC_CTLR;
   assign c_rst_n = ctrl1_q[C1_NRST];

   // outputs to line interface and host
   assign speed_hi  = ctrl1_q[C1_SPEED];
   assign cable_utp = ctrl7_q[C7_CABLE];
   assign h_irq     = irq_latch_q && ctrl1_q[C1_IEN];

   always_comb begin
      case (off)
         WIN_AW'(IDX_C0): ctrl_rd = ctrl0_q;
         WIN_AW'(IDX_C1): ctrl_rd = ctrl1_q;
         WIN_AW'(IDX_C7): ctrl_rd = ctrl7_q;
         default:         ctrl_rd = '0;
      endcase
   end

   always_comb begin
      h_rdata = '0;
      if (h_rd) begin
         case (kind)
            ACC_CTRL: h_rdata = DATA_W'(ctrl_rd);
            ACC_CTLR: h_rdata = ctlr_rd;
            ACC_ROM:  h_rdata = DATA_W'(rom_byte);
            default:  h_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/glue_window_chk.sv
module glue_window_chk
   import glue_pkg::*;
#(
   parameter int WIN_AW          = 3,
   parameter int CTRL_W          = 8,
   parameter int IRQ_SYNC_STAGES = 0
)(
   input logic              clk,
   input logic              rst_n,
   input logic [WIN_AW:0]   h_addr,
   input logic              h_rd,
   input logic              h_wr,
   input logic              h_word,
   input logic [7:0]        h_wlow,
   input logic              h_irq,
   input logic [WIN_AW:0]   c_addr,
   input logic              c_rd,
   input logic              c_wr,
   input logic [1:0]        c_be,
   input logic              c_irq,
   input logic              c_rst_n,
   input logic [CTRL_W-1:0] ctrl0_q,
   input logic [CTRL_W-1:0] ctrl1_q
);
   logic wr_c1;
   assign wr_c1 = h_wr && h_addr[WIN_AW] && (h_addr[WIN_AW-1:0] == WIN_AW'(IDX_C1));

   assert_rom_blocks_ctlr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((h_rd || h_wr) && !h_addr[WIN_AW] && !ctrl0_q[C0_MAP]) |-> (!c_rd && !c_wr));

   assert_page_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd || c_wr) |-> (c_addr[WIN_AW] == ctrl1_q[C1_RPAGE]
                          && c_addr[WIN_AW-1:0] == h_addr[WIN_AW-1:0]));

   assert_byte_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr && !h_word) |-> ($onehot(c_be) && (c_be[1] == h_addr[0])));

   assert_ctlr_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c1 |=> (c_rst_n == $past(h_wlow[C1_NRST])));

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl1_q[C1_IEN] |-> !h_irq);

   assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl0_q[C0_IRQ_STS] && !c_irq && !wr_c1) |=> ctrl0_q[C0_IRQ_STS]);

   if (IRQ_SYNC_STAGES == 0) begin : g_direct_irq
      assert_irq_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
         c_irq |=> ctrl0_q[C0_IRQ_STS]);
   end
endmodule

bind nic_glue_window glue_window_chk #(
   .WIN_AW          (WIN_AW),
   .CTRL_W          (CTRL_W),
   .IRQ_SYNC_STAGES (IRQ_SYNC_STAGES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .h_addr  (h_addr),
   .h_rd    (h_rd),
   .h_wr    (h_wr),
   .h_word  (h_word),
   .h_wlow  (h_wdata[7:0]),
   .h_irq   (h_irq),
   .c_addr  (c_addr),
   .c_rd    (c_rd),
   .c_wr    (c_wr),
   .c_be    (c_be),
   .c_irq   (c_irq),
   .c_rst_n (c_rst_n),
   .ctrl0_q (ctrl0_q),
   .ctrl1_q (ctrl1_q)
);

// File: tb/nic_glue_window_test.sv
module nic_glue_window_test;
   localparam logic [7:0]  T_MAN  = 8'h4D;
   localparam logic [7:0]  T_CARD = 8'h0D;
   localparam logic [7:0]  T_REV  = 8'h03;
   localparam logic [47:0] T_SA   = 48'h105AA5C33CE7;
   localparam logic [23:0] T_CFG  = 24'h9F31C6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  h_addr = '0;
   logic        h_rd = 1'b0, h_wr = 1'b0, h_word = 1'b0;
   logic [15:0] h_wdata = '0;
   logic [15:0] h_rdata;
   logic        h_irq;
   logic [3:0]  c_addr;
   logic        c_rd, c_wr;
   logic [1:0]  c_be;
   logic [15:0] c_wdata, c_rdata;
   logic        c_irq = 1'b0;
   logic        c_rst_n, speed_hi, cable_utp;

   int n_chk = 0;
   int n_bad = 0;
   int stub_hits = 0;
   logic [15:0] stub_mem [8];

   always #2 clk = ~clk;

   nic_glue_window #(
      .MANUF_ID(T_MAN), .CARD_ID(T_CARD), .CARD_REV(T_REV), .STATION_ADDR(T_SA)
   ) uut (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
      .h_word(h_word), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
      .c_addr(c_addr), .c_rd(c_rd), .c_wr(c_wr), .c_be(c_be), .c_wdata(c_wdata),
      .c_rdata(c_rdata), .c_irq(c_irq), .c_rst_n(c_rst_n), .speed_hi(speed_hi),
      .cable_utp(cable_utp), .cfg_bytes(T_CFG)
   );

   // controller register stub
   initial for (int i = 0; i < 8; i++) stub_mem[i] = '0;
   assign c_rdata = stub_mem[c_addr[3:1]];
   always @(posedge clk) begin
      if (c_rd || c_wr) stub_hits <= stub_hits + 1;
      if (c_wr) begin
         if (c_be[0]) stub_mem[c_addr[3:1]][7:0]  <= c_wdata[7:0];
         if (c_be[1]) stub_mem[c_addr[3:1]][15:8] <= c_wdata[15:8];
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [15:0] d, input logic w);
      @(negedge clk);
      h_addr = a; h_wdata = d; h_word = w; h_wr = 1'b1;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, input logic w, output logic [15:0] d);
      @(negedge clk);
      h_addr = a; h_word = w; h_rd = 1'b1;
      #1 d = h_rdata;
      h_rd = 1'b0;
   endtask

   function automatic logic [7:0] exp_p0(input int o);
      case (o)
         0: return T_MAN;
         1: return T_CARD;
         2: return T_REV;
         3, 4, 5: return T_CFG[(o-3)*8 +: 8];
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_p1(input int o);
      if (o >= 1 && o <= 6) return T_SA[(6-o)*8 +: 8];
      return 8'h00;
   endfunction

   task automatic t_reset;
      logic [15:0] d;
      bus_rd(4'h8, 1'b0, d); chk("R1 ctrl0", d, 16'h0000);
      bus_rd(4'h9, 1'b0, d); chk("R1 ctrl1", d, 16'h0000);
      bus_rd(4'hF, 1'b0, d); chk("R1 ctrl7", d, 16'h0000);
      chk("R1 outputs", {12'h0, c_rst_n, h_irq, speed_hi, cable_utp}, 16'h0000);
      bus_rd(4'h0, 1'b0, d); chk("R1 rom mapped", d, 16'h004D);
   endtask

   task automatic t_rom_pages;
      logic [15:0] d;
      for (int o = 0; o < 8; o++) begin
         bus_rd(4'(o), 1'b0, d); chk("R3 page0", d, {8'h00, exp_p0(o)});
      end
      bus_wr(4'h8, 16'h0008, 1'b0);
      for (int o = 0; o < 8; o++) begin
         bus_rd(4'(o), 1'b0, d); chk("R4 page1", d, {8'h00, exp_p1(o)});
      end
      bus_wr(4'h8, 16'h0000, 1'b0);
   endtask

   task automatic t_rom_isolation;
      logic [15:0] d;
      int h0;
      h0 = stub_hits;
      bus_wr(4'h2, 16'h00AB, 1'b0);
      bus_rd(4'h2, 1'b0, d); chk("R5 rom unchanged", d, {8'h00, T_REV});
      chk("R5 no controller access", 16'(stub_hits - h0), 16'h0000);
      bus_wr(4'h8, 16'h0004, 1'b0);
      bus_rd(4'h2, 1'b0, d); chk("R5 write ignored", d, 16'h0000);
      bus_wr(4'h8, 16'h0000, 1'b0);
   endtask

   task automatic t_ctrl_regs;
      logic [15:0] d;
      bus_wr(4'h8, 16'h00FF, 1'b0);
      bus_rd(4'h8, 1'b0, d); chk("R2 ctrl0 status ro", d, 16'h007F);
      bus_wr(4'h9, 16'h00F0, 1'b0);
      bus_rd(4'h9, 1'b0, d); chk("R2 ctrl1", d, 16'h00F0);
      bus_wr(4'hF, 16'h00A4, 1'b0);
      bus_rd(4'hF, 1'b0, d); chk("R2 ctrl7", d, 16'h00A4);
      bus_wr(4'hB, 16'h0077, 1'b0);
      bus_rd(4'hB, 1'b0, d); chk("R2 unused index", d, 16'h0000);
      bus_wr(4'h8, 16'h0000, 1'b0);
      bus_wr(4'h9, 16'h0000, 1'b0);
      bus_wr(4'hF, 16'h0000, 1'b0);
   endtask

   task automatic t_reset_speed_cable;
      bus_wr(4'h9, 16'h0001, 1'b0); chk("R7 release", 16'(c_rst_n), 16'h0001);
      bus_wr(4'h9, 16'h0000, 1'b0); chk("R7 hold", 16'(c_rst_n), 16'h0000);
      bus_wr(4'h9, 16'h0009, 1'b0); chk("R10 speed hi", 16'(speed_hi), 16'h0001);
      bus_wr(4'hF, 16'h0001, 1'b0); chk("R10 unshielded", 16'(cable_utp), 16'h0001);
      bus_wr(4'hF, 16'h0000, 1'b0); chk("R10 shielded", 16'(cable_utp), 16'h0000);
      bus_wr(4'h9, 16'h0001, 1'b0); chk("R10 speed lo", 16'(speed_hi), 16'h0000);
   endtask

   task automatic t_lanes_pages;
      logic [15:0] d;
      bus_wr(4'h8, 16'h0004, 1'b0);
      bus_wr(4'h0, 16'hBEEF, 1'b1);
      chk("R11 word write", stub_mem[0], 16'hBEEF);
      bus_rd(4'h0, 1'b1, d); chk("R11 word read", d, 16'hBEEF);
      bus_wr(4'h3, 16'h005C, 1'b0);
      chk("R11 odd byte write", stub_mem[1], 16'h5C00);
      bus_rd(4'h3, 1'b0, d); chk("R11 odd byte read", d, 16'h005C);
      bus_rd(4'h0, 1'b0, d); chk("R11 even byte read", d, 16'h00EF);
      bus_rd(4'h1, 1'b0, d); chk("R11 odd byte read hi", d, 16'h00BE);
      bus_wr(4'h9, 16'h0005, 1'b0);
      bus_wr(4'h2, 16'h1234, 1'b1);
      chk("R6 upper page write", stub_mem[5], 16'h1234);
      chk("R6 lower page intact", stub_mem[1], 16'h5C00);
      bus_rd(4'h2, 1'b1, d); chk("R6 upper page read", d, 16'h1234);
      bus_wr(4'h9, 16'h0001, 1'b0);
      bus_rd(4'h2, 1'b1, d); chk("R6 lower page read", d, 16'h5C00);
   endtask

   task automatic t_irq;
      logic [15:0] d;
      // request pulse while disabled
      @(negedge clk); c_irq = 1'b1;
      @(negedge clk); c_irq = 1'b0;
      bus_rd(4'h8, 1'b0, d); chk("R8 status set", d, 16'h0084);
      chk("R8 gated off", 16'(h_irq), 16'h0000);
      bus_wr(4'h9, 16'h0003, 1'b0); chk("R8 enabled drives", 16'(h_irq), 16'h0001);
      // clearing toggle, request gone
      bus_wr(4'h9, 16'h0001, 1'b0);
      bus_rd(4'h8, 1'b0, d); chk("R9 cleared", d, 16'h0004);
      bus_wr(4'h9, 16'h0003, 1'b0); chk("R9 stays low", 16'(h_irq), 16'h0000);
      // toggle with request held: coincident set and clear
      @(negedge clk); c_irq = 1'b1;
      bus_wr(4'h9, 16'h0001, 1'b0);
      bus_rd(4'h8, 1'b0, d); chk("R9 request wins", d, 16'h0084);
      bus_wr(4'h9, 16'h0003, 1'b0); chk("R9 relatched", 16'(h_irq), 16'h0001);
      @(negedge clk); c_irq = 1'b0;
      bus_wr(4'h9, 16'h0001, 1'b0);
      bus_wr(4'h9, 16'h0003, 1'b0); chk("R9 toggle clears", 16'(h_irq), 16'h0000);
      // write keeping enable low does not clear
      bus_wr(4'h9, 16'h0001, 1'b0);
      @(negedge clk); c_irq = 1'b1;
      @(negedge clk); c_irq = 1'b0;
      bus_wr(4'h9, 16'h0001, 1'b0);
      bus_rd(4'h8, 1'b0, d); chk("R9 no falling edge", d, 16'h0084);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_rom_pages;
      t_rom_isolation;
      t_ctrl_regs;
      t_reset_speed_cable;
      t_lanes_pages;
      t_irq;
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule